// File: doc/BRIEF.md
# Two-Stage Pipelined SAR Sequencer

This block is the digital controller for a successive-approximation converter split into a coarse stage and a fine stage, each resolving 5 bits. It runs from one conversion clock. From that clock it generates the control phases for the analog side: input sample, coarse comparator strobe, clearing of the fine capacitor array, the charge-sharing switch between the two arrays, and the fine comparator strobe. It also drives the bottom-plate bit controls of both arrays and folds each comparator decision back into that stage's trial code.

The conversion runs in frames. A frame is one hand-off step followed by five bit steps. In the hand-off step the fine array is cleared, the coarse residue is shared into it, and the coarse array samples the next input. In the five bit steps that follow, the coarse stage converts the new sample while the fine stage converts the previous one. Both stages are paced by one shared 6-flop one-hot step ring, so the block delivers one result per frame. Each result is a raw 5-bit coarse code and a raw 5-bit fine code. It comes with a one-clock done pulse and a tag naming the sample it belongs to. The analog arrays, the comparators and the references sit outside the block.

Top module: `pipesar_seq`

## Requirements
- R1: While `rst` is high, every phase output, both strobes and `done_o` are low, and `coarse_code_o`, `fine_code_o` and `tag_o` are zero. The first clock after release begins frame 0.
- R2: A frame lasts 6*SUB_LEN clocks, where SUB_LEN (default 6) is the number of clocks per step. Counting from 0 in the hand-off step, `clear_o` is high at clock 0, `share_o` at clock 2 and `sample_o` at clock 4, each for exactly one clock.
- R3: No two of `sample_o`, `clear_o` and `share_o` are high in the same clock. None of them is high in the clock right after another one.
- R4: In each bit step k = 1..5, `coarse_strobe_o` and `fine_strobe_o` are high together for exactly one clock, the second clock of the step. Each strobe therefore fires 5 times per frame.
- R5: The coarse stage performs a binary search, MSB first. Take the step where bit 5-k is the trial. At the strobe of that step, `coarse_bits_o` holds the decided higher bits, the trial bit set to 1, and all lower bits 0. On the last clock of the step, the trial bit becomes the value of `coarse_cmp_i`, and the next lower bit is set as the new trial.
- R6: Throughout the hand-off step, clear and share included, `fine_bits_o` is all zeros, meaning every fine bottom plate is on the negative reference. The fine stage then runs the same binary search as R5, driven by `fine_cmp_i`.
- R7: Let frame f sample input n = f. The coarse stage converts n during frame f, and the fine stage converts it during frame f+1. The result is reported in the first clock of frame f+2, with `coarse_code_o` set to the coarse decisions and `fine_code_o` set to the fine decisions of that same sample.
- R8: `done_o` is a one-clock pulse in the first clock of each frame from frame 2 on. It stays low in frames 0 and 1 and in every other clock.
- R9: `tag_o` gives the index of the reported sample modulo 2^TAG_W. The first sample after reset is 0.
- R10: `coarse_code_o`, `fine_code_o` and `tag_o` hold their value between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| coarse_cmp_i | input | 1 | Coarse comparator decision (1 keeps the trial bit) |
| fine_cmp_i | input | 1 | Fine comparator decision (1 keeps the trial bit) |
| sample_o | output | 1 | Coarse array tracks the input |
| coarse_strobe_o | output | 1 | Fires the coarse comparator |
| clear_o | output | 1 | Clears the fine array onto the negative reference |
| share_o | output | 1 | Closes the charge-sharing switch between the arrays |
| fine_strobe_o | output | 1 | Fires the fine comparator |
| coarse_bits_o | output | 5 | Coarse bottom-plate controls (1 = positive reference) |
| fine_bits_o | output | 5 | Fine bottom-plate controls (1 = positive reference) |
| done_o | output | 1 | One-clock pulse when a result is reported |
| coarse_code_o | output | 5 | Coarse code of the reported sample |
| fine_code_o | output | 5 | Fine code of the reported sample |
| tag_o | output | TAG_W | Index of the reported sample |

## Verification
In every bit step the coarse decision for sample n+1 and the fine decision for sample n land on the same clock edge. On the first clock of each frame, the done report for sample n-1 coincides with the clear of the fine array that held it. The bench drives all 1024 ten-bit inputs in a scrambled order, so consecutive samples have unrelated upper and lower halves. Its comparator models answer from whichever sample the bench's own frame schedule assigns to each stage. A result that mixes two samples, or that the clear overwrites before it is captured, shows up as a code that does not match the expected sample's bits under the reported tag.

// File: rtl/pipesar_pkg.sv
package pipesar_pkg;
  parameter int STAGE_BITS = 5;
  parameter int IDX_W      = $clog2(STAGE_BITS);
  parameter int RING_W     = STAGE_BITS + 1;

  typedef logic [STAGE_BITS-1:0] code_t;

  // Fold one comparator decision into a trial code and set the next trial bit.
  function automatic code_t sar_step(code_t cur, logic [IDX_W-1:0] idx, logic keep);
    code_t r;
    r = cur;
    r[idx] = keep;
    if (idx != '0) r[idx - 1'b1] = 1'b1;
    return r;
  endfunction

  // Initial trial pattern: MSB alone.
  function automatic code_t sar_seed();
    code_t r;
    r = '0;
    r[STAGE_BITS-1] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/pipesar_timer.sv
module pipesar_timer
  import pipesar_pkg::*;
#(
  parameter int SUB_LEN = 6,
  localparam int SUB_W = $clog2(SUB_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [RING_W-1:0] ring,
  output logic [SUB_W-1:0]  sub
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUB_LEN - 1);

  // One-hot step ring: all-zero is idle, bit 0 is the hand-off step,
  // bits 1..STAGE_BITS are the bit steps shared by both stages.
  always_ff @(posedge clk) begin
    if (rst) begin
      ring <= '0;
      sub  <= '0;
    end else if (ring == '0) begin
      ring <= RING_W'(1);
      sub  <= '0;
    end else if (sub == SUB_LAST) begin
      sub  <= '0;
      ring <= {ring[RING_W-2:0], ring[RING_W-1]};
    end else begin
      sub  <= sub + 1'b1;
    end
  end
endmodule

// File: rtl/pipesar_decode.sv
module pipesar_decode
  import pipesar_pkg::*;
#(
  parameter int SUB_LEN = 6,
  localparam int SUB_W = $clog2(SUB_LEN)
) (
  input  logic [RING_W-1:0] ring,
  input  logic [SUB_W-1:0]  sub,
  output logic              ev_clear,
  output logic              ev_share,
  output logic              ev_sample,
  output logic              ev_load,
  output logic              ev_strobe,
  output logic              ev_decide,
  output logic              ev_last,
  output logic [IDX_W-1:0]  bit_idx
);
  localparam logic [SUB_W-1:0] CLR_AT = SUB_W'(0);
  localparam logic [SUB_W-1:0] SHR_AT = SUB_W'(2);
  localparam logic [SUB_W-1:0] SMP_AT = SUB_W'(4);
  localparam logic [SUB_W-1:0] STB_AT = SUB_W'(1);
  localparam logic [SUB_W-1:0] DEC_AT = SUB_W'(SUB_LEN - 1);

  logic in_bits;
  assign in_bits = |ring[RING_W-1:1];

  assign ev_clear  = ring[0] && (sub == CLR_AT);
  assign ev_share  = ring[0] && (sub == SHR_AT);
  assign ev_sample = ring[0] && (sub == SMP_AT);
  assign ev_load   = ring[1] && (sub == CLR_AT);
  assign ev_strobe = in_bits && (sub == STB_AT);
  assign ev_decide = in_bits && (sub == DEC_AT);
  assign ev_last   = ring[RING_W-1] && (sub == DEC_AT);

  // Step k resolves bit STAGE_BITS-k.
  always_comb begin
    bit_idx = '0;
    for (int k = 1; k < RING_W; k++) begin
      if (ring[k]) bit_idx = IDX_W'(STAGE_BITS - k);
    end
  end
endmodule

// File: rtl/pipesar_stage.sv
module pipesar_stage
  import pipesar_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             decide,
  input  logic [IDX_W-1:0] bit_idx,
  input  logic             cmp,
  output code_t            code
);
  always_ff @(posedge clk) begin
    if (rst || clr) code <= '0;
    else if (load)  code <= sar_seed();
    else if (decide) code <= sar_step(code, bit_idx, cmp);
  end
endmodule

// File: rtl/pipesar_seq.sv
module pipesar_seq
  import pipesar_pkg::*;
#(
  parameter int SUB_LEN = 6,
  parameter int TAG_W   = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  coarse_cmp_i,
  input  logic                  fine_cmp_i,
  output logic                  sample_o,
  output logic                  coarse_strobe_o,
  output logic                  clear_o,
  output logic                  share_o,
  output logic                  fine_strobe_o,
  output logic [STAGE_BITS-1:0] coarse_bits_o,
  output logic [STAGE_BITS-1:0] fine_bits_o,
  output logic                  done_o,
  output logic [STAGE_BITS-1:0] coarse_code_o,
  output logic [STAGE_BITS-1:0] fine_code_o,
  output logic [TAG_W-1:0]      tag_o
);
  localparam int SUB_W = $clog2(SUB_LEN);

  logic [RING_W-1:0] ring;
  logic [SUB_W-1:0]  sub;
  logic ev_clear, ev_share, ev_sample, ev_load, ev_strobe, ev_decide, ev_last;
  logic [IDX_W-1:0]  bit_idx;
  code_t c_code, f_code;

  pipesar_timer #(.SUB_LEN(SUB_LEN)) u_timer (
    .clk(clk), .rst(rst), .ring(ring), .sub(sub)
  );

  pipesar_decode #(.SUB_LEN(SUB_LEN)) u_decode (
    .ring(ring), .sub(sub),
    .ev_clear(ev_clear), .ev_share(ev_share), .ev_sample(ev_sample),
    .ev_load(ev_load), .ev_strobe(ev_strobe), .ev_decide(ev_decide),
    .ev_last(ev_last), .bit_idx(bit_idx)
  );

  // Coarse array is cleared when it samples; fine array when it is cleared.
  pipesar_stage u_coarse (
    .clk(clk), .rst(rst), .clr(ev_sample), .load(ev_load),
    .decide(ev_decide), .bit_idx(bit_idx), .cmp(coarse_cmp_i), .code(c_code)
  );

  pipesar_stage u_fine (
    .clk(clk), .rst(rst), .clr(ev_clear), .load(ev_load),
    .decide(ev_decide), .bit_idx(bit_idx), .cmp(fine_cmp_i), .code(f_code)
  );

  // Pipeline bookkeeping between the stages.
  logic [TAG_W-1:0] smp_cnt, c_tag, f_tag;
  logic             c_valid, f_valid;
  code_t            c_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp_cnt <= '0;
      c_tag   <= '0;
      f_tag   <= '0;
      c_valid <= 1'b0;
      f_valid <= 1'b0;
      c_hold  <= '0;
      done_o  <= 1'b0;
      coarse_code_o <= '0;
      fine_code_o   <= '0;
      tag_o         <= '0;
    end else begin
      done_o <= 1'b0;
      if (ev_share) begin
        f_valid <= c_valid;
        f_tag   <= c_tag;
        c_hold  <= c_code;
      end
      if (ev_sample) begin
        c_valid <= 1'b1;
        c_tag   <= smp_cnt;
        smp_cnt <= smp_cnt + 1'b1;
      end
      if (ev_last && f_valid) begin
        done_o        <= 1'b1;
        coarse_code_o <= c_hold;
        fine_code_o   <= sar_step(f_code, IDX_W'(0), fine_cmp_i);
        tag_o         <= f_tag;
      end
    end
  end

  assign sample_o        = ev_sample;
  assign clear_o         = ev_clear;
  assign share_o         = ev_share;
  assign coarse_strobe_o = ev_strobe;
  assign fine_strobe_o   = ev_strobe;
  assign coarse_bits_o   = c_code;
  // Fine plates stay on the negative reference for the whole hand-off step.
  assign fine_bits_o     = ring[0] ? '0 : f_code;
endmodule

// File: rtl/pipesar_seq_chk.sv
module pipesar_seq_chk
  import pipesar_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  sample_o,
  input logic                  clear_o,
  input logic                  share_o,
  input logic                  coarse_strobe_o,
  input logic                  fine_strobe_o,
  input logic [STAGE_BITS-1:0] coarse_bits_o,
  input logic [STAGE_BITS-1:0] fine_bits_o,
  input logic                  done_o,
  input logic                  ev_last
);
  logic any_phase;
  assign any_phase = sample_o || clear_o || share_o;

  // R3
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sample_o, clear_o, share_o}));

  // R3
  phase_gap_chk: assert property (@(posedge clk) disable iff (rst)
    any_phase |=> !any_phase);

  // R2
  share_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    share_o |-> $past(clear_o, 2));

  // R6
  lsb_neg_ref_chk: assert property (@(posedge clk) disable iff (rst)
    (clear_o || share_o) |-> (fine_bits_o == '0));

  // R4
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (coarse_strobe_o || fine_strobe_o) |=> !(coarse_strobe_o || fine_strobe_o));

  // R5
  strobe_trial_chk: assert property (@(posedge clk) disable iff (rst)
    coarse_strobe_o |-> ($countones(coarse_bits_o) >= 1));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R7
  done_src_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> $past(ev_last));
endmodule

bind pipesar_seq pipesar_seq_chk u_chk (
  .clk(clk), .rst(rst),
  .sample_o(sample_o), .clear_o(clear_o), .share_o(share_o),
  .coarse_strobe_o(coarse_strobe_o), .fine_strobe_o(fine_strobe_o),
  .coarse_bits_o(coarse_bits_o), .fine_bits_o(fine_bits_o),
  .done_o(done_o), .ev_last(ev_last)
);

// File: tb/pipesar_seq_tb.sv
`timescale 1ns/1ps
module pipesar_seq_tb;
  localparam int NB    = 5;
  localparam int SUB   = 6;
  localparam int FRAME = (NB + 1) * SUB;
  localparam int TAGW  = 4;
  localparam int NSAMP = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic coarse_cmp, fine_cmp;
  logic sample_o, coarse_strobe_o, clear_o, share_o, fine_strobe_o, done_o;
  logic [NB-1:0] coarse_bits_o, fine_bits_o, coarse_code_o, fine_code_o;
  logic [TAGW-1:0] tag_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int cur_c = 0;
  int cur_f = 0;

  always #4 clk = ~clk;

  // Comparator models: keep the trial when the held value reaches it.
  assign coarse_cmp = ((cur_c >> 5) & 31) >= int'(coarse_bits_o);
  assign fine_cmp   = (cur_f & 31) >= int'(fine_bits_o);

  pipesar_seq #(.SUB_LEN(SUB), .TAG_W(TAGW)) u_dut (
    .clk(clk), .rst(rst), .coarse_cmp_i(coarse_cmp), .fine_cmp_i(fine_cmp),
    .sample_o(sample_o), .coarse_strobe_o(coarse_strobe_o), .clear_o(clear_o),
    .share_o(share_o), .fine_strobe_o(fine_strobe_o),
    .coarse_bits_o(coarse_bits_o), .fine_bits_o(fine_bits_o), .done_o(done_o),
    .coarse_code_o(coarse_code_o), .fine_code_o(fine_code_o), .tag_o(tag_o)
  );

  function automatic int vin_of(int n);
    return (n * 397 + 5) % 1024;
  endfunction

  // Expected plate pattern at the strobe of bit step k for a 5-bit target.
  function automatic int trial_of(int v5, int k);
    int idx;
    idx = NB - k;
    return ((v5 >> (idx + 1)) << (idx + 1)) | (1 << idx);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit prev_any;
    prev_any = 1'b0;
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      chk({sample_o, clear_o, share_o, coarse_strobe_o, fine_strobe_o, done_o} == 6'b0,
          "R1 phases idle in reset",
          int'({sample_o, clear_o, share_o, coarse_strobe_o, fine_strobe_o, done_o}), 0);
      chk(coarse_code_o == 0 && fine_code_o == 0 && tag_o == 0, "R1 codes cleared in reset",
          int'({coarse_code_o, fine_code_o, tag_o}), 0);
    end
    rst = 1'b0;

    for (int c = 0; c < (NSAMP + 2) * FRAME; c++) begin
      int pos, f, step, sub, cnt;
      bit any;
      @(negedge clk);
      pos  = c % FRAME;
      f    = c / FRAME;
      step = pos / SUB;
      sub  = pos % SUB;
      if (pos == 2) cur_f = cur_c;
      if (pos == 4) cur_c = vin_of(f);

      // R2: phase placement
      chk(clear_o == (pos == 0), "R2 clear timing", int'(clear_o), int'(pos == 0));
      chk(share_o == (pos == 2), "R2 share timing", int'(share_o), int'(pos == 2));
      chk(sample_o == (pos == 4), "R2 sample timing", int'(sample_o), int'(pos == 4));

      // R3: exclusive with a dead clock, judged at the ports
      cnt = int'(sample_o) + int'(clear_o) + int'(share_o);
      any = (cnt != 0);
      chk(cnt <= 1 && !(any && prev_any), "R3 dead time between phases", cnt, 1);
      prev_any = any;

      // R4: strobes
      chk(coarse_strobe_o == (step >= 1 && sub == 1), "R4 coarse strobe",
          int'(coarse_strobe_o), int'(step >= 1 && sub == 1));
      chk(fine_strobe_o == (step >= 1 && sub == 1), "R4 fine strobe",
          int'(fine_strobe_o), int'(step >= 1 && sub == 1));

      // R5: coarse binary search on sample f
      if (step >= 1 && sub == 1)
        chk(int'(coarse_bits_o) == trial_of((vin_of(f) >> 5) & 31, step), "R5 coarse trial",
            int'(coarse_bits_o), trial_of((vin_of(f) >> 5) & 31, step));

      // R6: fine plates low in hand-off, then binary search on sample f-1
      if (step == 0)
        chk(fine_bits_o == 0, "R6 fine plates on negative reference", int'(fine_bits_o), 0);
      else if (sub == 1 && f >= 1)
        chk(int'(fine_bits_o) == trial_of(vin_of(f - 1) & 31, step), "R6 fine trial",
            int'(fine_bits_o), trial_of(vin_of(f - 1) & 31, step));

      // R8: done pulse placement and start-up suppression
      chk(done_o == (pos == 0 && f >= 2), "R8 done pulse", int'(done_o), int'(pos == 0 && f >= 2));

      // R7, R9: reported result belongs to sample f-2
      if (pos == 0 && f >= 2) begin
        chk(int'(coarse_code_o) == ((vin_of(f - 2) >> 5) & 31), "R7 coarse code",
            int'(coarse_code_o), (vin_of(f - 2) >> 5) & 31);
        chk(int'(fine_code_o) == (vin_of(f - 2) & 31), "R7 fine code",
            int'(fine_code_o), vin_of(f - 2) & 31);
        chk(int'(tag_o) == ((f - 2) % (1 << TAGW)), "R9 tag", int'(tag_o), (f - 2) % (1 << TAGW));
      end

      // R10: result held mid-frame
      if (pos == FRAME / 2 && f >= 2)
        chk(int'({coarse_code_o, fine_code_o}) == vin_of(f - 2) && int'(tag_o) == ((f - 2) % (1 << TAGW)),
            "R10 result held", int'({coarse_code_o, fine_code_o}), vin_of(f - 2));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule